// File: doc/BRIEF.md
# Hardwired Instruction-Cycle and Interrupt Sequencer

This block is the timing and control core of a small 16-bit accumulator machine. A 4-bit step counter feeds a one-hot step decoder, and a 3-bit opcode decoder classifies the held instruction. Together they drive fetch, decode, optional indirect address resolution and the seven memory-reference instructions. They also drive a three-step interrupt cycle. The block owns the address, program counter, data and temporary registers, plus the indirect, interrupt-pending and interrupt-enable flags. It talks to a 4096-word by 16-bit memory whose read data is valid in the same cycle as the read strobe.

The accumulator itself lives outside. For STA the block takes its value on `acc_i`. After AND, ADD and LDA it issues a one-hot accumulator command together with the fetched operand. Register-reference and I/O instructions are not executed here. The block only raises a strobe in their execute step and returns to fetch. The I/O unit drives the interrupt enable through set and clear strobes. The input and output ready flags request interrupts.

Top module: `isc_seq`

## Requirements
- R1: While `rst_ni` is low and right after it rises, the step is T0 (`t_state_o` = 1), `pc_o` = 0, `int_cycle_o` = 0 and `ien_o` = 0.
- R2: An instruction word holds the indirect flag in bit 15, the opcode in bits 14..12 and the address in bits 11..0. With no pending interrupt, T0 copies PC to the address register. T1 reads memory at that address into the instruction register and increments PC. T2 loads the address field and the indirect flag. Exactly one step bit is high at all times, and an instruction ends by returning to T0.
- R3: Opcode 7 ends in T3 after four cycles. In T3, `reg_exec_o` pulses when bit 15 is 0 and `io_exec_o` pulses when bit 15 is 1. PC keeps its incremented value.
- R4: Opcodes 0, 1 and 2 are AND, ADD and LDA. In T3 an indirect word is replaced by the low 12 bits read at its address. T4 reads the operand into DR. In T5, `ac_op_o` shows bit 0 for AND, bit 1 for ADD or bit 2 for LDA, with `dr_o` holding the operand. Each takes six cycles.
- R5: STA (opcode 3) writes `acc_i` to the effective address in T4 and takes five cycles. Read and write strobes are never high together.
- R6: BUN (opcode 4) sets PC to the effective address in T4 and takes five cycles.
- R7: BSA (opcode 5) writes the return address (PC after fetch, zero-extended) to the effective address. It then sets PC to the effective address plus one and takes six cycles.
- R8: ISZ (opcode 6) writes the operand plus one (16-bit wrap) back to memory. If that result is zero, PC is incremented once more. It takes seven cycles.
- R9: The interrupt-pending flag is set at a clock edge outside T0..T2 when `ien_o` is 1 and `fgi_i` or `fgo_i` is 1. It never sets while `ien_o` is 0. `ien_set_i` sets and `ien_clr_i` clears the enable, with clear taking priority.
- R10: With the pending flag set, the next T0..T2 form an interrupt cycle instead of a fetch. The cycle stores PC at address 0 and sets PC to 1, then clears the enable, the pending flag and the step.
- R11: A `halt_i` pulse freezes the step, PC and all internal state, and suppresses all memory and exec strobes, until reset.
- R12: Addresses and PC wrap modulo 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Stop request, sticky until reset |
| fgi_i | input | 1 | Input-ready flag |
| fgo_i | input | 1 | Output-ready flag |
| ien_set_i | input | 1 | Interrupt-enable set strobe |
| ien_clr_i | input | 1 | Interrupt-enable clear strobe |
| acc_i | input | 16 | Accumulator value for STA |
| mem_rdata_i | input | 16 | Memory read data, same cycle |
| mem_addr_o | output | 12 | Memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 16 | Memory write data |
| pc_o | output | 12 | Program counter |
| ir_o | output | 16 | Held instruction |
| dr_o | output | 16 | Data register |
| t_state_o | output | 16 | One-hot step T0..T15 |
| int_cycle_o | output | 1 | Interrupt-pending flag |
| ien_o | output | 1 | Interrupt enable |
| reg_exec_o | output | 1 | Register-reference execute strobe |
| io_exec_o | output | 1 | I/O execute strobe |
| ac_op_o | output | 3 | Accumulator command {LDA, ADD, AND} |

## Verification
The bench sweeps all seven memory-reference opcodes, each in direct and indirect form, at the low and high ends of the address space. A design that took the pointer word whole, or skipped the indirect read, lands on the wrong effective address. BSA and ISZ at address 4095 and ISZ on 0xFFFF exercise the 12-bit wrap and the skip on a zero result. A wrong carry or a missed skip would show as a wrong final PC. An interrupt is raised only after the enable is set by an I/O strobe. This catches a pending flag that samples the enable too early, a return address saved from the wrong register, or an enable left set after the cycle. The halt case hits mid-STA, so a design that leaks one write or one step after halt corrupts memory or moves the step.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned SC_W   = 4;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'd0, OP_ADD = 3'd1, OP_LDA = 3'd2, OP_STA = 3'd3,
    OP_BUN = 3'd4, OP_BSA = 3'd5, OP_ISZ = 3'd6, OP_EXT = 3'd7
  } opcode_e;
endpackage

// File: rtl/isc_timing.sv
module isc_timing #(
  parameter int unsigned SC_W = 4,
  localparam int unsigned N_T = 1 << SC_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           clr_i,
  output logic [N_T-1:0] t_o
);
  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sc_q <= '0;
    else if (run_i) sc_q <= clr_i ? '0 : sc_q + SC_W'(1);
  end

  for (genvar g = 0; g < N_T; g++) begin : g_dec
    assign t_o[g] = (sc_q == SC_W'(g));
  end
endmodule

// File: rtl/isc_opdec.sv
module isc_opdec #(
  parameter int unsigned OP_W = 3,
  localparam int unsigned N_D = 1 << OP_W
) (
  input  logic [OP_W-1:0] op_i,
  output logic [N_D-1:0]  d_o
);
  for (genvar g = 0; g < N_D; g++) begin : g_dec
    assign d_o[g] = (op_i == OP_W'(g));
  end
endmodule

// File: rtl/isc_seq.sv
module isc_seq
  import isc_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned SCW = SC_W,
  localparam int unsigned N_T = 1 << SCW,
  localparam int unsigned N_D = 1 << OP_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           halt_i,
  input  logic           fgi_i,
  input  logic           fgo_i,
  input  logic           ien_set_i,
  input  logic           ien_clr_i,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic [AW-1:0]  mem_addr_o,
  output logic           mem_rd_o,
  output logic           mem_wr_o,
  output logic [DW-1:0]  mem_wdata_o,
  output logic [AW-1:0]  pc_o,
  output logic [DW-1:0]  ir_o,
  output logic [DW-1:0]  dr_o,
  output logic [N_T-1:0] t_state_o,
  output logic           int_cycle_o,
  output logic           ien_o,
  output logic           reg_exec_o,
  output logic           io_exec_o,
  output logic [2:0]     ac_op_o
);
  logic [AW-1:0] ar_q, pc_q, tr_q;
  logic [DW-1:0] ir_q, dr_q;
  logic          ind_q, r_q, ien_q, halted_q;
  logic [N_T-1:0] t;
  logic [N_D-1:0] d;
  logic run, sc_clr;
  logic fetch0, fetch1, dec2, ind3, ext3, rt0, rt1, rt2;
  logic ld_op, rd, wr, dr_zero, r_set;

  assign run = ~halted_q & ~halt_i;

  isc_timing #(.SC_W(SCW)) i_timing (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .clr_i(sc_clr), .t_o(t)
  );

  isc_opdec #(.OP_W(OP_W)) i_opdec (
    .op_i(ir_q[DW-2 -: OP_W]), .d_o(d)
  );

  assign fetch0 = ~r_q & t[0];
  assign fetch1 = ~r_q & t[1];
  assign dec2   = ~r_q & t[2];
  assign rt0    =  r_q & t[0];
  assign rt1    =  r_q & t[1];
  assign rt2    =  r_q & t[2];
  assign ind3   = ~d[OP_EXT] & ind_q & t[3];
  assign ext3   =  d[OP_EXT] & t[3];
  assign ld_op  = d[OP_AND] | d[OP_ADD] | d[OP_LDA];
  assign dr_zero = (dr_q == '0);

  assign rd = fetch1 | ind3 | (t[4] & (ld_op | d[OP_ISZ]));
  assign wr = rt1 | (t[4] & (d[OP_STA] | d[OP_BSA])) | (t[6] & d[OP_ISZ]);

  assign sc_clr = ext3 | rt2
                | (t[4] & (d[OP_STA] | d[OP_BUN]))
                | (t[5] & (ld_op | d[OP_BSA]))
                | (t[6] & d[OP_ISZ]);

  // request sampled only outside fetch/decode steps
  assign r_set = ~(t[0] | t[1] | t[2]) & ien_q & (fgi_i | fgo_i);

  always_comb begin
    mem_wdata_o = dr_q;
    if (rt1)                      mem_wdata_o = {{(DW-AW){1'b0}}, tr_q};
    else if (t[4] & d[OP_STA])    mem_wdata_o = acc_i;
    else if (t[4] & d[OP_BSA])    mem_wdata_o = {{(DW-AW){1'b0}}, pc_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) halted_q <= 1'b0;
    else if (halt_i) halted_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ar_q <= '0; pc_q <= '0; tr_q <= '0; ir_q <= '0; dr_q <= '0;
      ind_q <= 1'b0; r_q <= 1'b0; ien_q <= 1'b0;
    end else if (run) begin
      if (fetch0)                    ar_q <= pc_q;
      else if (dec2)                 ar_q <= ir_q[AW-1:0];
      else if (ind3)                 ar_q <= mem_rdata_i[AW-1:0];
      else if (t[4] & d[OP_BSA])     ar_q <= ar_q + AW'(1);
      else if (rt0)                  ar_q <= '0;

      if (fetch1 | rt2)                          pc_q <= pc_q + AW'(1);
      else if ((t[4] & d[OP_BUN]) | (t[5] & d[OP_BSA])) pc_q <= ar_q;
      else if (t[6] & d[OP_ISZ] & dr_zero)       pc_q <= pc_q + AW'(1);
      else if (rt1)                              pc_q <= '0;

      if (fetch1) ir_q  <= mem_rdata_i;
      if (dec2)   ind_q <= ir_q[DW-1];
      if (rt0)    tr_q  <= pc_q;

      if (t[4] & (ld_op | d[OP_ISZ])) dr_q <= mem_rdata_i;
      else if (t[5] & d[OP_ISZ])      dr_q <= dr_q + DW'(1);

      if (rt2 | ien_clr_i) ien_q <= 1'b0;
      else if (ien_set_i)  ien_q <= 1'b1;

      if (rt2)        r_q <= 1'b0;
      else if (r_set) r_q <= 1'b1;
    end
  end

  assign mem_addr_o  = ar_q;
  assign mem_rd_o    = run & rd;
  assign mem_wr_o    = run & wr;
  assign pc_o        = pc_q;
  assign ir_o        = ir_q;
  assign dr_o        = dr_q;
  assign t_state_o   = t;
  assign int_cycle_o = r_q;
  assign ien_o       = ien_q;
  assign reg_exec_o  = run & ext3 & ~ind_q;
  assign io_exec_o   = run & ext3 &  ind_q;
  assign ac_op_o     = {3{run & t[5]}} & {d[OP_LDA], d[OP_ADD], d[OP_AND]};
endmodule

// File: rtl/isc_seq_chk.sv
module isc_seq_chk #(
  parameter int unsigned AW  = 12,
  parameter int unsigned SCW = 4,
  localparam int unsigned N_T = 1 << SCW
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           halt_i,
  input logic [AW-1:0]  pc_o,
  input logic [N_T-1:0] t_state_o,
  input logic           mem_rd_o,
  input logic           mem_wr_o,
  input logic           int_cycle_o,
  input logic           ien_o,
  input logic           reg_exec_o,
  input logic           io_exec_o
);
  logic halt_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) halt_seen_q <= 1'b0;
    else if (halt_i) halt_seen_q <= 1'b1;
  end

  p_one_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(t_state_o) == 1);

  p_rw_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  p_ext_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_exec_o || io_exec_o) |=> t_state_o[0]);

  p_no_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ien_o && !int_cycle_o) |=> !int_cycle_o);

  p_int_exit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_cycle_o && t_state_o[2] && !halt_i && !halt_seen_q)
      |=> (!int_cycle_o && !ien_o && t_state_o[0]));

  p_halt_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i || halt_seen_q) |-> (!mem_wr_o && !mem_rd_o && !reg_exec_o && !io_exec_o));

  p_halt_freeze_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i || halt_seen_q) |=> ($stable(pc_o) && $stable(t_state_o)));
endmodule

bind isc_seq isc_seq_chk #(.AW(AW), .SCW(SCW)) i_chk (.*);

// File: tb/test_isc_seq.sv
`timescale 1ns/100ps
module test_isc_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        halt_i = 1'b0, fgi_i = 1'b0, fgo_i = 1'b0;
  logic        ien_set_i = 1'b0, ien_clr_i = 1'b0;
  logic [15:0] acc_i = '0;
  logic [15:0] mem_rdata_i, mem_wdata_o, ir_o, dr_o, t_state_o;
  logic [11:0] mem_addr_o, pc_o;
  logic        mem_rd_o, mem_wr_o, int_cycle_o, ien_o, reg_exec_o, io_exec_o;
  logic [2:0]  ac_op_o;
  logic [15:0] mem [4096];
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  isc_seq i_isc_seq (.*);

  assign mem_rdata_i = mem[mem_addr_o];
  always @(posedge clk_i) if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wipe();
    for (int a = 0; a < 4096; a++) mem[a] = '0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    tick(2);
    rst_ni = 1'b1;
  endtask

  task automatic run_mref(int op, int ind, int k);
    logic [11:0] addr, ea;
    logic [15:0] opnd, acc, sum;
    addr = (k == 0) ? 12'h00A : (k == 1) ? 12'h7F0 : 12'hFFF;
    ea   = ind ? (addr ^ 12'hAAA) : addr;
    opnd = (k == 0) ? 16'hFFFF : 16'h1234 + 16'(k);
    acc  = 16'hC3A5 ^ 16'(k);
    sum  = opnd + 16'h1;
    wipe();
    mem[0] = {ind[0], op[2:0], addr};
    if (ind != 0) mem[addr] = {4'h9, ea};
    mem[ea] = opnd;
    acc_i = acc;
    do_reset();
    tick(1);
    chk("R2 fetch rd", mem_rd_o, 1);
    chk("R2 fetch addr", mem_addr_o, 0);
    case (op)
      0, 1, 2: begin
        tick(4);
        chk("R4 ac_op", ac_op_o, 32'(1 << op));
        chk("R4 dr", dr_o, opnd);
        tick(1);
        chk("R4 pc", pc_o, 1);
      end
      3: begin tick(4); chk("R5 sta mem", mem[ea], acc); chk("R5 pc", pc_o, 1); end
      4: begin tick(4); chk("R6 bun pc", pc_o, ea); end
      5: begin
        tick(5);
        chk("R7 bsa ret", mem[ea], 1);
        chk("R7 R12 bsa pc", pc_o, 12'(ea + 12'h1));
      end
      default: begin
        tick(6);
        chk("R8 isz mem", mem[ea], sum);
        chk("R8 isz pc", pc_o, (sum == 0) ? 2 : 1);
      end
    endcase
    chk("R2 back to t0", t_state_o, 1);
  endtask

  initial begin
    wipe();
    tick(1);
    chk("R1 t_state", t_state_o, 1);
    chk("R1 pc", pc_o, 0);
    chk("R1 int", int_cycle_o, 0);
    chk("R1 ien", ien_o, 0);
    do_reset();
    chk("R1 t after", t_state_o, 1);

    for (int op = 0; op < 7; op++)
      for (int ind = 0; ind < 2; ind++)
        for (int k = 0; k < 3; k++) run_mref(op, ind, k);

    // R3 register-reference and I/O strobes
    wipe(); mem[0] = 16'h7800; do_reset();
    tick(3);
    chk("R3 reg strobe", reg_exec_o, 1);
    chk("R3 io quiet", io_exec_o, 0);
    tick(1);
    chk("R3 t0", t_state_o, 1);
    chk("R3 pc", pc_o, 1);
    wipe(); mem[0] = 16'hF400; do_reset();
    tick(3);
    chk("R3 io strobe", io_exec_o, 1);
    chk("R3 reg quiet", reg_exec_o, 0);

    // R12 wrap of PC on fetch
    wipe(); mem[0] = 16'h4FFF; mem[12'hFFF] = 16'h7800; do_reset();
    tick(5);
    chk("R12 pc fff", pc_o, 12'hFFF);
    tick(4);
    chk("R12 pc wrap", pc_o, 0);

    // R9 no request without enable
    wipe(); mem[0] = 16'h4010; fgi_i = 1'b1; do_reset();
    tick(5);
    chk("R9 no int", int_cycle_o, 0);
    chk("R9 pc", pc_o, 12'h010);

    // R9 R10 enabled interrupt
    wipe(); mem[0] = 16'hF080; mem[1] = 16'h4010; do_reset();
    tick(3);
    ien_set_i = 1'b1;
    tick(1);
    ien_set_i = 1'b0;
    chk("R9 ien set", ien_o, 1);
    chk("R9 not yet", int_cycle_o, 0);
    tick(5);
    chk("R9 pending", int_cycle_o, 1);
    chk("R9 pc", pc_o, 12'h010);
    tick(3);
    fgi_i = 1'b0;
    chk("R10 saved", mem[0], 16'h0010);
    chk("R10 pc", pc_o, 1);
    chk("R10 ien", ien_o, 0);
    chk("R10 r", int_cycle_o, 0);
    chk("R10 t0", t_state_o, 1);

    // R9 enable clear
    wipe(); fgo_i = 1'b0; mem[0] = 16'hF080; mem[1] = 16'hF040; do_reset();
    tick(3); ien_set_i = 1'b1; tick(1); ien_set_i = 1'b0;
    tick(3); ien_clr_i = 1'b1; tick(1); ien_clr_i = 1'b0;
    chk("R9 ien clr", ien_o, 0);

    // R11 halt mid STA
    wipe(); mem[0] = 16'h3100; acc_i = 16'h1234; do_reset();
    tick(2);
    halt_i = 1'b1;
    tick(1);
    halt_i = 1'b0;
    tick(20);
    chk("R11 t frozen", t_state_o, 16'h0004);
    chk("R11 pc frozen", pc_o, 1);
    chk("R11 no write", mem[12'h100], 0);
    do_reset();
    chk("R11 R1 reset pc", pc_o, 0);
    tick(5);
    chk("R11 resumed", mem[12'h100], 16'h1234);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule